// File: doc/BRIEF.md
# SPI Master Shift Engine

This block is the serial core of a single-lane SPI master. It pulls words from an upstream transmit FIFO, shifts them out on MOSI, and captures the same number of bits from MISO into words for a downstream receive FIFO. Both FIFOs connect through per-word handshakes. One 32-bit configuration word sets the behaviour: the clock divider, the word length (8, 12, 16 or 32 bits), the bit order, the SCK idle level, the SCK edge on which data is driven, the chip-select idle level, a software chip-select force bit, auto-clear and multi-word framing.

A two-bit run-enable input starts the engine. Bit 1 enables transmit and starts and stops the frame. Bit 0 enables receive, which lets captured words be pushed. The engine runs one word per frame, or `length+1` words per frame when multi-word framing is set. It then reports the frame end and, if auto-clear is set, puts chip select back to its idle level. A transmit FIFO that runs dry in the middle of a frame stalls SCK at its idle level and raises one underflow event. A full receive FIFO drops the word and raises an overflow event.

Top module: `spi_shift_engine`

## Requirements
- R1: SCK holds each level for divider+1 controller clocks, where the divider is in configuration bits 15:0. Outside a word, SCK sits at the idle level given by bit 20, and it also sits there out of reset.
- R2: Configuration bits 27:26 set the word length as 0 = 8 bits, 1 = 12 bits, 2 = 16 bits and 3 = 32 bits. Each word takes that many SCK cycles. The transmitted word is the low N bits of the transmit data. The received word sits right-aligned in the receive data, with zeros above it.
- R3: Configuration bit 22 set shifts the most significant bit first. Bit 22 clear shifts the least significant bit first. The same order applies to MOSI and MISO.
- R4: Configuration bit 23 set drives MOSI on rising SCK edges and samples MISO on falling edges. Clear swaps the two. When the first edge of a word is a drive edge, that edge presents the first bit. The word comes out correctly for every combination of idle level and drive edge.
- R5: Chip select sits at the level of configuration bit 21 when inactive and at the opposite level when active. It is active while a frame is loading or shifting. Setting bit 18 forces it active at any time.
- R6: With configuration bit 31 set, a frame carries length+1 words, where length is the length input. With bit 31 clear, a frame carries exactly one word whatever the length input holds.
- R7: A rising transmit-enable bit (run bit 1) starts a frame. Clearing it returns the engine to idle on the next clock, with SCK and chip select idle and no frame end. Receive-enable (run bit 0) clear stops all pushes and all overflow events.
- R8: With auto-clear (configuration bit 30) set, chip select returns to idle as soon as the frame ends. With it clear, chip select stays active until transmit-enable is cleared.
- R9: When a word is due and the transmit FIFO is empty, one underflow pulse is raised, SCK stays idle and nothing is popped until data arrives. The frame then resumes with the correct data.
- R10: When a word completes while receive is enabled and the receive FIFO is full, an overflow pulse is raised and no push happens.
- R11: Every completed word gives a one-cycle word-done pulse. The last word of a frame also gives a one-cycle frame-end pulse, once per frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Controller clock |
| rstN | input | 1 | Active-low synchronous reset |
| ctrlWord | input | 32 | Configuration word (divider, format, order, edges, chip select, modes) |
| frameLenM1 | input | LEN_W | Words per frame minus one, used in multi-word mode |
| runEn | input | 2 | Bit 1 transmit enable / run, bit 0 receive enable |
| txValid | input | 1 | Transmit FIFO holds a word |
| txData | input | 32 | Transmit FIFO head word |
| txReady | output | 1 | Pop strobe to the transmit FIFO |
| rxValid | output | 1 | Push strobe to the receive FIFO |
| rxData | output | 32 | Received word, right-aligned |
| rxFull | input | 1 | Receive FIFO cannot accept a word |
| sck | output | 1 | Serial clock |
| mosi | output | 1 | Serial data out |
| miso | input | 1 | Serial data in |
| csPin | output | 1 | Chip select pin |
| wordDone | output | 1 | One-cycle pulse per completed word |
| frameEnd | output | 1 | One-cycle pulse at the end of a frame |
| txUnderflow | output | 1 | One-cycle pulse when a word is due and no data is present |
| rxOverflow | output | 1 | One-cycle pulse when a received word is dropped |

## Verification
A broken edge counter or drive/sample decision shows at the pins within a single word. The SCK cycle count per word changes, or a bit of MOSI lands shifted or rotated. A slave model that collects bits on the sampling edges catches either fault, and the check is swept over every format, bit order, idle level and drive edge. A wrong word counter or a stuck state shows by the end of the first frame as a missing or extra frame-end pulse, a wrong pop count, or a chip-select level that does not match the auto-clear setting. A stall flag that fails to re-arm shows within the first starved word as a wrong underflow count.

// File: rtl/spi_eng_pkg.sv
package spi_eng_pkg;
  localparam int DATA_W   = 32;
  localparam int DIV_W    = 16;
  localparam int BITCNT_W = $clog2(2 * DATA_W + 1);

  typedef struct packed {
    logic load;
    logic run;
  } engStrobe_t;

  typedef enum logic [1:0] {
    S_IDLE,
    S_LOAD,
    S_SHIFT,
    S_DONE
  } engState_t;

  function automatic logic [BITCNT_W-1:0] wordBits(input logic [1:0] fmt);
    case (fmt)
      2'd0:    return BITCNT_W'(8);
      2'd1:    return BITCNT_W'(12);
      2'd2:    return BITCNT_W'(16);
      default: return BITCNT_W'(DATA_W);
    endcase
  endfunction
endpackage

// File: rtl/spi_eng_dp.sv
module spi_eng_dp
  import spi_eng_pkg::*;
(
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [DIV_W-1:0]      divider,
  input  logic [1:0]            fmt,
  input  logic                  msbFirst,
  input  logic                  sckIdle,
  input  logic                  driveRise,
  input  engStrobe_t            strb,
  input  logic [DATA_W-1:0]     txData,
  input  logic                  miso,
  output logic                  sckOut,
  output logic                  mosiOut,
  output logic                  wordEnd,
  output logic [DATA_W-1:0]     rxWord
);
  localparam int CW = BITCNT_W;

  logic [DIV_W-1:0]  tickCnt;
  logic              sckReg;
  logic [CW-1:0]     edgeCnt;
  logic [DATA_W-1:0] txShift;
  logic [DATA_W-1:0] rxShift;
  logic [DATA_W-1:0] rxShiftNext;
  logic [DATA_W-1:0] maskBits;
  logic [CW-1:0]     nBits;
  logic [CW-1:0]     padAmt;
  logic [CW-1:0]     lastEdge;
  logic              edgeNow;
  logic              driveNow;
  logic              sampleNow;
  logic              shiftNow;

  assign nBits    = wordBits(fmt);
  assign padAmt   = CW'(DATA_W) - nBits;
  assign lastEdge = (nBits << 1) - CW'(1);
  assign maskBits = (DATA_W'(1) << nBits) - DATA_W'(1);

  // an edge moves SCK away from its present level; rising when it is low now
  assign edgeNow   = strb.run && (tickCnt == divider);
  assign driveNow  = edgeNow && ((!sckReg) == driveRise);
  assign sampleNow = edgeNow && !driveNow;
  // the very first edge, if it is a drive edge, presents bit 0 already loaded
  assign shiftNow  = driveNow && (edgeCnt != '0);
  assign wordEnd   = edgeNow && (edgeCnt == lastEdge);

  always_comb begin
    rxShiftNext = rxShift;
    if (sampleNow) begin
      if (msbFirst) rxShiftNext = {rxShift[DATA_W-2:0], miso};
      else          rxShiftNext = {miso, rxShift[DATA_W-1:1]};
    end
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      tickCnt <= '0;
      sckReg  <= 1'b0;
      edgeCnt <= '0;
      txShift <= '0;
      rxShift <= '0;
    end else begin
      rxShift <= rxShiftNext;
      if (!strb.run || edgeNow) tickCnt <= '0;
      else                      tickCnt <= tickCnt + DIV_W'(1);
      if (strb.load) begin
        sckReg  <= sckIdle;
        edgeCnt <= '0;
        txShift <= msbFirst ? (txData << padAmt) : txData;
      end else begin
        if (edgeNow) begin
          sckReg  <= !sckReg;
          edgeCnt <= edgeCnt + CW'(1);
        end
        if (shiftNow) txShift <= msbFirst ? (txShift << 1) : (txShift >> 1);
      end
    end
  end

  assign sckOut  = strb.run ? sckReg : sckIdle;
  assign mosiOut = msbFirst ? txShift[DATA_W-1] : txShift[0];
  assign rxWord  = msbFirst ? (rxShiftNext & maskBits) : (rxShiftNext >> padAmt);

  AST_HALF_PERIOD: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && (tickCnt != divider)) |=> $stable(sckReg)); // R1
  AST_DRIVE_EDGE_ONLY: assert property (@(posedge clk) disable iff (!rstN)
    (strb.run && !driveNow) |=> $stable(txShift)); // R4
endmodule

// File: rtl/spi_eng_ctrl.sv
module spi_eng_ctrl
  import spi_eng_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             multi,
  input  logic             autoClr,
  input  logic             csIdle,
  input  logic             csForce,
  input  logic [LEN_W-1:0] frameLenM1,
  input  logic [1:0]       runEn,
  input  logic             txValid,
  input  logic             rxFull,
  input  logic             wordEnd,
  output engStrobe_t       strb,
  output logic             txReady,
  output logic             rxValid,
  output logic             wordDone,
  output logic             frameEnd,
  output logic             txUnderflow,
  output logic             rxOverflow,
  output logic             csPin
);
  engState_t        state;
  logic [LEN_W-1:0] wordsLeft;
  logic             stalled;
  logic             txEn;
  logic             rxEn;
  logic             lastWord;
  logic             csActive;

  assign txEn     = runEn[1];
  assign rxEn     = runEn[0];
  assign lastWord = !multi || (wordsLeft == '0);

  assign strb.load   = (state == S_LOAD) && txEn && txValid;
  assign strb.run    = (state == S_SHIFT);
  assign txReady     = strb.load;
  assign txUnderflow = (state == S_LOAD) && txEn && !txValid && !stalled;
  assign wordDone    = (state == S_SHIFT) && txEn && wordEnd;
  assign rxValid     = wordDone && rxEn && !rxFull;
  assign rxOverflow  = wordDone && rxEn && rxFull;
  assign frameEnd    = wordDone && lastWord;

  assign csActive = (state == S_LOAD) || (state == S_SHIFT) ||
                    ((state == S_DONE) && !autoClr) || csForce;
  assign csPin    = csActive ? !csIdle : csIdle;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      state     <= S_IDLE;
      wordsLeft <= '0;
      stalled   <= 1'b0;
    end else if (!txEn) begin
      state   <= S_IDLE;
      stalled <= 1'b0;
    end else begin
      case (state)
        S_IDLE: begin
          state     <= S_LOAD;
          wordsLeft <= frameLenM1;
          stalled   <= 1'b0;
        end
        S_LOAD: begin
          if (txValid) begin
            state   <= S_SHIFT;
            stalled <= 1'b0;
          end else begin
            stalled <= 1'b1;
          end
        end
        S_SHIFT: begin
          if (wordEnd) begin
            if (lastWord) state <= S_DONE;
            else begin
              state     <= S_LOAD;
              wordsLeft <= wordsLeft - LEN_W'(1);
            end
          end
        end
        default: state <= S_DONE;
      endcase
    end
  end

  AST_POP_NEEDS_DATA: assert property (@(posedge clk) disable iff (!rstN)
    txReady |-> txValid); // R9
  AST_UFLOW_ONCE: assert property (@(posedge clk) disable iff (!rstN)
    txUnderflow |=> !txUnderflow); // R9
  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rstN)
    rxValid |-> !rxFull); // R10
  AST_FRAME_END_SINGLE: assert property (@(posedge clk) disable iff (!rstN)
    frameEnd |=> !frameEnd); // R11
  AST_STOP_TO_IDLE: assert property (@(posedge clk) disable iff (!rstN)
    !runEn[1] |=> (state == S_IDLE)); // R7
  AST_CS_AUTO_CLR: assert property (@(posedge clk) disable iff (!rstN)
    (frameEnd && autoClr && !csForce && $stable(csIdle)) |=> (csPin == csIdle)); // R8
endmodule

// File: rtl/spi_shift_engine.sv
module spi_shift_engine
  import spi_eng_pkg::*;
#(
  parameter int LEN_W = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic [31:0]      ctrlWord,
  input  logic [LEN_W-1:0] frameLenM1,
  input  logic [1:0]       runEn,
  input  logic             txValid,
  input  logic [31:0]      txData,
  output logic             txReady,
  output logic             rxValid,
  output logic [31:0]      rxData,
  input  logic             rxFull,
  output logic             sck,
  output logic             mosi,
  input  logic             miso,
  output logic             csPin,
  output logic             wordDone,
  output logic             frameEnd,
  output logic             txUnderflow,
  output logic             rxOverflow
);
  engStrobe_t strb;
  logic       wordEnd;
  logic       unusedCtrl;

  assign unusedCtrl = ^{ctrlWord[17:16], ctrlWord[19], ctrlWord[25:24], ctrlWord[29:28]};

  spi_eng_ctrl #(.LEN_W(LEN_W)) ctrl_i (
    .clk        (clk),
    .rstN       (rstN),
    .multi      (ctrlWord[31]),
    .autoClr    (ctrlWord[30]),
    .csIdle     (ctrlWord[21]),
    .csForce    (ctrlWord[18]),
    .frameLenM1 (frameLenM1),
    .runEn      (runEn),
    .txValid    (txValid),
    .rxFull     (rxFull),
    .wordEnd    (wordEnd),
    .strb       (strb),
    .txReady    (txReady),
    .rxValid    (rxValid),
    .wordDone   (wordDone),
    .frameEnd   (frameEnd),
    .txUnderflow(txUnderflow),
    .rxOverflow (rxOverflow),
    .csPin      (csPin)
  );

  spi_eng_dp dp_i (
    .clk      (clk),
    .rstN     (rstN),
    .divider  (ctrlWord[DIV_W-1:0]),
    .fmt      (ctrlWord[27:26]),
    .msbFirst (ctrlWord[22]),
    .sckIdle  (ctrlWord[20]),
    .driveRise(ctrlWord[23]),
    .strb     (strb),
    .txData   (txData),
    .miso     (miso),
    .sckOut   (sck),
    .mosiOut  (mosi),
    .wordEnd  (wordEnd),
    .rxWord   (rxData)
  );
endmodule

// File: tb/spi_shift_engine_tb.sv
module spi_shift_engine_tb_top;
  localparam int CLK_PERIOD = 10;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic [31:0] ctrlWord = '0;
  logic [15:0] frameLenM1 = '0;
  logic [1:0]  runEn = 2'b00;
  logic        txValid;
  logic [31:0] txData;
  logic        txReady, rxValid, rxFull = 1'b0;
  logic [31:0] rxData;
  logic        sck, mosi, csPin, wordDone, frameEnd, txUnderflow, rxOverflow;
  logic        miso = 1'b0;

  int checks = 0;
  int failures = 0;
  int cyc = 0;
  bit finished = 0;

  logic [31:0] txWords [0:7];
  logic [31:0] slaveWords [0:7];
  logic [31:0] rxGot [0:7];
  logic [31:0] slvCap [0:7];
  logic [3:0]  txIdx = '0;
  int          txLimit = 0;
  int          wdCnt = 0, feCnt = 0, ufCnt = 0, ofCnt = 0, rxCnt = 0;
  logic        clrCnt = 1'b0;
  bit          slvOn = 0;
  int          curN = 8, curMsb = 0, curDrv = 0, curDiv = 0;
  int          sc = 0, sw = 0, eiw = 0, hpBad = 0, lastCyc = 0;
  logic        prevSck = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  assign txValid = (int'(txIdx) < txLimit);
  assign txData  = txWords[txIdx[2:0]];

  spi_shift_engine dut_i (
    .clk(clk), .rstN(rstN), .ctrlWord(ctrlWord), .frameLenM1(frameLenM1),
    .runEn(runEn), .txValid(txValid), .txData(txData), .txReady(txReady),
    .rxValid(rxValid), .rxData(rxData), .rxFull(rxFull), .sck(sck),
    .mosi(mosi), .miso(miso), .csPin(csPin), .wordDone(wordDone),
    .frameEnd(frameEnd), .txUnderflow(txUnderflow), .rxOverflow(rxOverflow)
  );

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (clrCnt) begin
      txIdx <= '0; wdCnt <= 0; feCnt <= 0; ufCnt <= 0; ofCnt <= 0; rxCnt <= 0;
    end else begin
      if (txReady) txIdx <= txIdx + 4'd1;
      if (wordDone) wdCnt <= wdCnt + 1;
      if (frameEnd) feCnt <= feCnt + 1;
      if (txUnderflow) ufCnt <= ufCnt + 1;
      if (rxOverflow) ofCnt <= ofCnt + 1;
      if (rxValid) begin
        rxGot[rxCnt[2:0]] <= rxData;
        rxCnt <= rxCnt + 1;
      end
    end
  end

  function automatic int bitPos(input int s);
    return (curMsb != 0) ? (curN - 1 - s) : s;
  endfunction

  // slave model: captures MOSI and advances MISO on each sampling edge
  always @(sck or clrCnt) begin
    if (clrCnt) begin
      sc = 0; sw = 0; eiw = 0; hpBad = 0;
      for (int w = 0; w < 8; w++) slvCap[w] = '0;
      miso = slaveWords[0][bitPos(0)];
      prevSck = sck;
    end else if (slvOn && (sck !== prevSck)) begin
      prevSck = sck;
      eiw = eiw + 1;
      if (eiw > 1 && (cyc - lastCyc) != curDiv + 1) hpBad = hpBad + 1;
      lastCyc = cyc;
      if (sck == ((curDrv != 0) ? 1'b0 : 1'b1)) begin
        if (sw < 8) slvCap[sw][bitPos(sc)] = mosi;
        sc = sc + 1;
        if (sc == curN) begin sc = 0; sw = sw + 1; end
        if (sw < 8) miso = slaveWords[sw][bitPos(sc)];
      end
      if (eiw == 2 * curN) eiw = 0;
    end else begin
      prevSck = sck;
    end
  end

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  function automatic int nbits(input int fmt);
    case (fmt)
      0: return 8;
      1: return 12;
      2: return 16;
      default: return 32;
    endcase
  endfunction

  function automatic logic [31:0] maskOf(input int n);
    if (n >= 32) return 32'hFFFF_FFFF;
    return (32'd1 << n) - 32'd1;
  endfunction

  function automatic logic [31:0] mkCtrl(input int fmt, msb, idle, drv, div, csIdl, csF, aclr, multi);
    logic [31:0] c;
    c = '0;
    c[15:0]  = div[15:0];
    c[18]    = csF[0];
    c[20]    = idle[0];
    c[21]    = csIdl[0];
    c[22]    = msb[0];
    c[23]    = drv[0];
    c[27:26] = fmt[1:0];
    c[30]    = aclr[0];
    c[31]    = multi[0];
    return c;
  endfunction

  task automatic setup(input int fmt, msb, idle, drv, div, csIdl, csF, aclr, multi, lenM1, lim, seed);
    @(negedge clk);
    slvOn = 0;
    curN = nbits(fmt); curMsb = msb; curDrv = drv; curDiv = div;
    ctrlWord = mkCtrl(fmt, msb, idle, drv, div, csIdl, csF, aclr, multi);
    frameLenM1 = lenM1[15:0];
    txLimit = lim;
    for (int w = 0; w < 8; w++) begin
      txWords[w]    = 32'h9E37_79B9 * 32'(seed * 8 + w + 1);
      slaveWords[w] = 32'h7F4A_7C15 ^ (32'h0101_0101 * 32'(seed + w));
    end
    @(negedge clk); clrCnt = 1'b1;
    @(negedge clk); clrCnt = 1'b0;
    slvOn = 1;
  endtask

  task automatic waitFrame(input int limit);
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (feCnt != 0) break;
    end
  endtask

  task automatic runFrame(input int fmt, msb, idle, drv, div, csIdl, aclr, multi, lenM1, seed);
    int nw;
    logic [31:0] m;
    nw = (multi != 0) ? lenM1 + 1 : 1;
    setup(fmt, msb, idle, drv, div, csIdl, 0, aclr, multi, lenM1, 8, seed);
    m = maskOf(nbits(fmt));
    runEn = 2'b11;
    waitFrame(20000);
    chk(feCnt == 1, "R11 frame end count", 32'(feCnt), 32'd1);
    chk(wdCnt == nw, "R6 R11 word done count", 32'(wdCnt), 32'(nw));
    chk(int'(txIdx) == nw, "R6 words popped", 32'(txIdx), 32'(nw));
    for (int w = 0; w < nw; w++) begin
      chk(slvCap[w] == (txWords[w] & m), "R2 R3 R4 mosi word", slvCap[w], txWords[w] & m);
      chk(rxGot[w] == (slaveWords[w] & m), "R2 R3 R4 miso word", rxGot[w], slaveWords[w] & m);
    end
    chk(hpBad == 0, "R1 half period", 32'(hpBad), 32'd0);
    chk(sck == idle[0], "R1 idle level after frame", 32'(sck), 32'(idle[0]));
    chk(csPin == ((aclr != 0) ? csIdl[0] : !csIdl[0]), "R8 chip select after frame",
        32'(csPin), 32'((aclr != 0) ? csIdl[0] : !csIdl[0]));
    slvOn = 0;
    runEn = 2'b00;
    @(negedge clk);
    chk(csPin == csIdl[0], "R7 stop releases chip select", 32'(csPin), 32'(csIdl[0]));
  endtask

  initial begin
    while (!finished) begin
      @(posedge clk);
      if (cyc > 150000) begin
        failures++;
        $display("FAIL watchdog actual=%0d expected<150000", cyc);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
      end
    end
  end

  initial begin
    ctrlWord = mkCtrl(0, 1, 1, 0, 0, 1, 0, 1, 1);
    repeat (3) @(negedge clk);
    chk(sck == 1'b1, "R1 reset sck idle", 32'(sck), 32'd1);
    chk(csPin == 1'b1, "R5 reset chip select idle", 32'(csPin), 32'd1);
    chk({txReady, rxValid, frameEnd, wordDone} == 4'b0, "R11 reset strobes quiet",
        32'({txReady, rxValid, frameEnd, wordDone}), 32'd0);
    rstN = 1'b1;
    @(negedge clk);

    // full sweep of format, order, idle level and drive edge
    for (int fmt = 0; fmt < 4; fmt++)
      for (int msb = 0; msb < 2; msb++)
        for (int idle = 0; idle < 2; idle++)
          for (int drv = 0; drv < 2; drv++)
            runFrame(fmt, msb, idle, drv, (fmt + idle + drv) % 3, msb ^ drv,
                     idle ^ (fmt & 1), 1, 1, fmt * 8 + msb * 4 + idle * 2 + drv);

    // R6: single-word mode ignores the length input
    runFrame(1, 1, 0, 1, 1, 0, 1, 0, 3, 40);
    // R6: four-word frame with a larger divider
    runFrame(2, 0, 1, 0, 4, 1, 0, 1, 3, 41);

    // R5: software force bit asserts chip select while idle
    setup(0, 1, 0, 0, 0, 1, 1, 1, 1, 1, 8, 42);
    chk(csPin == 1'b0, "R5 force asserts chip select", 32'(csPin), 32'd0);
    setup(0, 1, 0, 0, 0, 1, 0, 1, 1, 1, 8, 42);
    chk(csPin == 1'b1, "R5 chip select idle without force", 32'(csPin), 32'd1);

    // R9: underflow stall between words
    setup(0, 1, 1, 1, 1, 0, 0, 1, 1, 1, 1, 43);
    runEn = 2'b11;
    for (int i = 0; i < 5000 && wdCnt == 0; i++) @(negedge clk);
    repeat (40) @(negedge clk);
    chk(ufCnt == 1, "R9 single underflow pulse", 32'(ufCnt), 32'd1);
    chk(sck == 1'b1, "R9 sck idle during stall", 32'(sck), 32'd1);
    chk(wdCnt == 1 && int'(txIdx) == 1, "R9 no progress during stall", 32'(wdCnt), 32'd1);
    txLimit = 2;
    waitFrame(5000);
    chk(feCnt == 1, "R9 frame resumes", 32'(feCnt), 32'd1);
    chk(slvCap[1] == (txWords[1] & 32'hFF), "R9 resumed word data", slvCap[1], txWords[1] & 32'hFF);
    chk(ufCnt == 1, "R9 no extra underflow", 32'(ufCnt), 32'd1);
    slvOn = 0; runEn = 2'b00;

    // R10: full receive FIFO drops each word
    setup(0, 1, 0, 0, 0, 1, 0, 1, 1, 1, 8, 44);
    rxFull = 1'b1; runEn = 2'b11;
    waitFrame(5000);
    chk(ofCnt == 2, "R10 overflow per word", 32'(ofCnt), 32'd2);
    chk(rxCnt == 0, "R10 no push when full", 32'(rxCnt), 32'd0);
    slvOn = 0; runEn = 2'b00;

    // R7: receive disabled gives neither push nor overflow
    setup(0, 1, 0, 0, 0, 1, 0, 1, 1, 1, 8, 45);
    runEn = 2'b10;
    waitFrame(5000);
    chk(wdCnt == 2, "R7 transmit-only frame completes", 32'(wdCnt), 32'd2);
    chk(ofCnt == 0 && rxCnt == 0, "R7 receive disabled quiet", 32'(ofCnt + rxCnt), 32'd0);
    slvOn = 0; runEn = 2'b00; rxFull = 1'b0;

    // R7: abort in the middle of a word
    setup(3, 0, 0, 1, 2, 0, 0, 0, 1, 3, 8, 46);
    runEn = 2'b11;
    repeat (30) @(negedge clk);
    runEn = 2'b00;
    @(negedge clk);
    chk(sck == 1'b0, "R7 abort sck idle", 32'(sck), 32'd0);
    chk(csPin == 1'b0, "R7 abort chip select idle", 32'(csPin), 32'd0);
    repeat (100) @(negedge clk);
    chk(feCnt == 0 && wdCnt == 0, "R7 abort no frame end", 32'(feCnt + wdCnt), 32'd0);
    slvOn = 0;

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule